// File: doc/BRIEF.md
# Strobed Row/Column DRAM Grid Model

This block is a synthesizable, cycle-level behavioural model of a small dynamic memory chip. Its storage holds `ROWS x COLS` words of `WIDTH` bits, 16 words of 8 bits by default, laid out as a square grid. A separate buffer holds one row. The address pins are only wide enough for one row index or one column index. A row strobe gives the pins their row meaning, and a column strobe gives them their column meaning. A row strobe copies a whole row into the buffer. Each later column strobe reads one word of that buffer onto the data bus, or writes the data bus into the buffer.

The controller is a state machine with six named states:
- `ST_CLOSED`: no row is held in the buffer.
- `ST_SENSE`: a row is copied from the array into the buffer.
- `ST_OPEN`: a row is held and column accesses are accepted.
- `ST_RESTORE`: the buffer is written back to its array row.
- `ST_REF_SENSE`: the refresh half that copies the indicated row into the buffer.
- `ST_REF_RESTORE`: the refresh half that writes that row back.

The named transitions are:
- *activate*: `ST_CLOSED` to `ST_SENSE` on a row strobe.
- *sensed*: `ST_SENSE` to `ST_OPEN`.
- *close*: `ST_OPEN` to `ST_RESTORE` on a close request.
- *switch*: `ST_OPEN` to `ST_RESTORE` on a row strobe, with the new row held pending.
- *reopen*: `ST_RESTORE` to `ST_SENSE` when a row is pending.
- *closed*: `ST_RESTORE` to `ST_CLOSED` when no row is pending.
- *refresh*: `ST_CLOSED` to `ST_REF_SENSE`, then to `ST_REF_RESTORE`, then back to `ST_CLOSED`.

Periodic refresh scheduling and analog effects are left to the user. The model only performs a refresh when it is asked for one.

Top module: `dram_grid_model`

## Requirements
- R1: After reset the bus is undriven (`rd_oe`=0, `rd_data`=0), no row is open, and every stored word reads as 0.
- R2: The `addr` pins are `max(clog2(ROWS),clog2(COLS))` bits wide, 2 by default. They are read as a row index in a cycle with `row_stb` and as a column index in a cycle with `col_stb`.
- R3: A `row_stb` while closed opens the addressed row. A column strobe is accepted from the second cycle after the row strobe.
- R4: In an open row, a read column strobe (`col_stb`=1, `col_wr`=0) drives the addressed word with `rd_oe`=1 in the next cycle, for one cycle only. Back-to-back column strobes read several words of the same row without reopening it.
- R5: A write column strobe (`col_stb`=1, `col_wr`=1) stores `wr_data` into the buffer word, and the bus stays undriven. A later read of that column in the same open row returns the new value.
- R6: `close_row` in an open row writes the whole buffer back to its array row, and the block is closed two cycles later.
- R7: A `row_stb` in an open row first writes the buffer back to the old row and then loads the new one. A column strobe is accepted from the third cycle after the row strobe.
- R8: A column strobe while closed is ignored: no bus drive, and no stored word changes.
- R9: `refresh_req` while closed, with `addr` as the row, rewrites that row unchanged within three cycles without driving the bus. If `row_stb` arrives in the same cycle, `row_stb` wins.
- R10: Any strobe or request that arrives during `ST_SENSE`, `ST_RESTORE`, `ST_REF_SENSE` or `ST_REF_RESTORE` is ignored.
- R11: In an open row, `row_stb` beats `close_row`, and either of them cancels a column strobe in the same cycle. `refresh_req` is ignored while a row is open.
- R12: `rd_data` is 0 whenever `rd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Shared row/column index |
| row_stb | input | 1 | Row strobe: open or switch row |
| col_stb | input | 1 | Column strobe: access one word of the open row |
| col_wr | input | 1 | With `col_stb`: 1 writes, 0 reads |
| close_row | input | 1 | Write back and close the open row |
| refresh_req | input | 1 | Refresh the row on `addr` (closed only) |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data, 0 when not driven |
| rd_oe | output | 1 | Read data valid / bus driven |

## Verification
The bench drives every input just after a falling edge and samples at the next falling edge. Latencies are counted from the rising edge after the command:
- Read data appears one edge after the read column strobe.
- A row strobe from closed leaves the row open after two edges.
- A row switch, or a refresh, completes after three edges.
- A close completes after two edges.

The bench's command tasks wait exactly those counts before issuing the next command. Each read pushes its expected word into a queue. A monitor pops one entry on every falling edge where `rd_oe` is high, and any drive without a pending expectation counts as a failure. An ignored command is therefore caught as a missing or surplus bus cycle, as well as by the later reads of the stored data.

// File: rtl/dram_grid_pkg.sv
package dram_grid_pkg;

    typedef enum logic [2:0] {
        ST_CLOSED,
        ST_SENSE,
        ST_OPEN,
        ST_RESTORE,
        ST_REF_SENSE,
        ST_REF_RESTORE
    } dram_state_e;

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RAW    = $clog2(ROWS),
    localparam int LINE_W = COLS * WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW-1:0]    rd_row,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [RAW-1:0]    wr_row,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] cells [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[r] <= '0;
            end else if (wr_en && wr_row == RAW'(r)) begin
                cells[r] <= wr_line;
            end
        end
    end

    assign rd_line = cells[rd_row];

    // R6
    row_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(wr_row)] == $past(wr_line));

endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int CAW    = $clog2(COLS),
    localparam int LINE_W = COLS * WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [LINE_W-1:0] load_line,
    input  logic              col_wr_en,
    input  logic [CAW-1:0]    col_sel,
    input  logic [WIDTH-1:0]  col_wdata,
    output logic [WIDTH-1:0]  col_rdata,
    output logic [LINE_W-1:0] line_q
);

    logic [WIDTH-1:0] words [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[c] <= '0;
            end else if (load_en) begin
                words[c] <= load_line[c*WIDTH +: WIDTH];
            end else if (col_wr_en && col_sel == CAW'(c)) begin
                words[c] <= col_wdata;
            end
        end
        assign line_q[c*WIDTH +: WIDTH] = words[c];
    end

    assign col_rdata = words[col_sel];

    // R5
    col_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr_en && !load_en) |=> words[$past(col_sel)] == $past(col_wdata));

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dram_grid_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int ADDR_W = 2,
    localparam int RAW   = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb,
    input  logic              col_stb,
    input  logic              col_wr,
    input  logic              close_row,
    input  logic              refresh_req,
    input  logic [ADDR_W-1:0] addr,
    output dram_state_e       state_o,
    output logic [RAW-1:0]    tgt_row_o,
    output logic              buf_load_o,
    output logic              buf_wr_o,
    output logic              arr_wr_o,
    output logic              rd_go_o
);

    dram_state_e    state_q, state_d;
    logic [RAW-1:0] tgt_row_q, tgt_row_d;
    logic [RAW-1:0] pend_row_q, pend_row_d;
    logic           pend_q, pend_d;
    logic           open_free;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_CLOSED;
            tgt_row_q  <= '0;
            pend_row_q <= '0;
            pend_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            tgt_row_q  <= tgt_row_d;
            pend_row_q <= pend_row_d;
            pend_q     <= pend_d;
        end
    end

    // transitions
    always_comb begin
        state_d    = state_q;
        tgt_row_d  = tgt_row_q;
        pend_row_d = pend_row_q;
        pend_d     = pend_q;
        unique case (state_q)
            ST_CLOSED: begin
                if (row_stb) begin
                    tgt_row_d = addr[RAW-1:0];
                    state_d   = ST_SENSE;
                end else if (refresh_req) begin
                    tgt_row_d = addr[RAW-1:0];
                    state_d   = ST_REF_SENSE;
                end
            end
            ST_SENSE: state_d = ST_OPEN;
            ST_OPEN: begin
                if (row_stb) begin
                    pend_row_d = addr[RAW-1:0];
                    pend_d     = 1'b1;
                    state_d    = ST_RESTORE;
                end else if (close_row) begin
                    pend_d  = 1'b0;
                    state_d = ST_RESTORE;
                end
            end
            ST_RESTORE: begin
                if (pend_q) begin
                    tgt_row_d = pend_row_q;
                    pend_d    = 1'b0;
                    state_d   = ST_SENSE;
                end else begin
                    state_d = ST_CLOSED;
                end
            end
            ST_REF_SENSE:   state_d = ST_REF_RESTORE;
            ST_REF_RESTORE: state_d = ST_CLOSED;
            default:        state_d = ST_CLOSED;
        endcase
    end

    // outputs
    assign open_free = !row_stb && !close_row;

    always_comb begin
        buf_load_o = 1'b0;
        arr_wr_o   = 1'b0;
        buf_wr_o   = 1'b0;
        rd_go_o    = 1'b0;
        unique case (state_q)
            ST_SENSE, ST_REF_SENSE:     buf_load_o = 1'b1;
            ST_RESTORE, ST_REF_RESTORE: arr_wr_o   = 1'b1;
            ST_OPEN: begin
                buf_wr_o = open_free && col_stb && col_wr;
                rd_go_o  = open_free && col_stb && !col_wr;
            end
            default: ;
        endcase
    end

    assign state_o   = state_q;
    assign tgt_row_o = tgt_row_q;

    // R3
    activate_senses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSED && row_stb) |=> state_q == ST_SENSE);

    // R6
    close_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && close_row && !row_stb) |=> (state_q == ST_RESTORE && !pend_q));

    // R7
    switch_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTORE && pend_q) |=> (state_q == ST_SENSE && tgt_row_q == $past(pend_row_q)));

    // R9
    refresh_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_REF_SENSE |=> state_q == ST_REF_RESTORE);

    // R10
    sense_uninterrupted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SENSE |=> state_q == ST_OPEN);

endmodule

// File: rtl/dram_grid_model.sv
module dram_grid_model
    import dram_grid_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RAW    = $clog2(ROWS),
    localparam int CAW    = $clog2(COLS),
    localparam int ADDR_W = (RAW > CAW) ? RAW : CAW,
    localparam int LINE_W = COLS * WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              row_stb,
    input  logic              col_stb,
    input  logic              col_wr,
    input  logic              close_row,
    input  logic              refresh_req,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_oe
);

    dram_state_e       state;
    logic [RAW-1:0]    tgt_row;
    logic              buf_load, buf_wr, arr_wr, rd_go;
    logic [LINE_W-1:0] arr_line, buf_line;
    logic [WIDTH-1:0]  col_word;

    dram_strobe_ctrl #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_stb    (row_stb),
        .col_stb    (col_stb),
        .col_wr     (col_wr),
        .close_row  (close_row),
        .refresh_req(refresh_req),
        .addr       (addr),
        .state_o    (state),
        .tgt_row_o  (tgt_row),
        .buf_load_o (buf_load),
        .buf_wr_o   (buf_wr),
        .arr_wr_o   (arr_wr),
        .rd_go_o    (rd_go)
    );

    dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_row (tgt_row),
        .rd_line(arr_line),
        .wr_en  (arr_wr),
        .wr_row (tgt_row),
        .wr_line(buf_line)
    );

    dram_row_buffer #(.COLS(COLS), .WIDTH(WIDTH)) u_rowbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (buf_load),
        .load_line(arr_line),
        .col_wr_en(buf_wr),
        .col_sel  (addr[CAW-1:0]),
        .col_wdata(wr_data),
        .col_rdata(col_word),
        .line_q   (buf_line)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_oe   <= 1'b0;
        end else begin
            rd_data <= rd_go ? col_word : '0;
            rd_oe   <= rd_go;
        end
    end

    // R12
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> rd_data == '0);

    // R8
    drive_from_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(state == ST_OPEN));

    // R4
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && !rd_go) |=> !rd_oe);

endmodule

// File: tb/dram_grid_model_bench.sv
module dram_grid_model_bench;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int WIDTH = 8;
    localparam int AW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             row_stb = 0, col_stb = 0, col_wr = 0, close_row = 0, refresh_req = 0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             rd_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [WIDTH-1:0] exp_q [$];
    string            tag_q [$];
    logic [WIDTH-1:0] model [ROWS][COLS];
    logic [WIDTH-1:0] mon_exp;
    string            mon_tag;

    always #2 clk = ~clk;

    dram_grid_model #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dram_grid_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
        .col_wr(col_wr), .close_row(close_row), .refresh_req(refresh_req),
        .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    function automatic void check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // monitor: pops one expectation per driven bus cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_oe) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected drive", int'(rd_data), 0);
                end else begin
                    mon_exp = exp_q.pop_front();
                    mon_tag = tag_q.pop_front();
                    check(rd_data == mon_exp, mon_tag, int'(rd_data), int'(mon_exp));
                end
            end else if (rd_data != '0) begin
                check(0, "R12 data while undriven", int'(rd_data), 0);
            end
        end
    end

    task automatic clr();
        row_stb = 0; col_stb = 0; col_wr = 0; close_row = 0; refresh_req = 0;
    endtask

    // R3: open from closed, ready two edges later
    task automatic open_row(input int r);
        row_stb = 1; addr = AW'(r);
        @(negedge clk); clr();
        @(negedge clk);
    endtask

    // R7: switch rows, ready three edges later
    task automatic switch_row(input int r);
        row_stb = 1; addr = AW'(r);
        @(negedge clk); clr();
        repeat (2) @(negedge clk);
    endtask

    // R6
    task automatic close_it();
        close_row = 1;
        @(negedge clk); clr();
        @(negedge clk);
    endtask

    task automatic wr(input int r, input int c, input logic [WIDTH-1:0] d);
        col_stb = 1; col_wr = 1; addr = AW'(c); wr_data = d;
        model[r][c] = d;
        @(negedge clk); clr();
    endtask

    task automatic rd(input int c, input logic [WIDTH-1:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        col_stb = 1; addr = AW'(c);
        @(negedge clk); clr();
    endtask

    function automatic logic [WIDTH-1:0] pat(input int r, input int c);
        return WIDTH'(r * 37 + c * 11 + 8'h5A);
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                model[r][c] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_oe == 1'b0, "R1 oe after reset", int'(rd_oe), 0);
        check(rd_data == '0, "R1 data after reset", int'(rd_data), 0);
        rst_n = 1;
        @(negedge clk);
        open_row(2);
        rd(1, 8'h00, "R1 cleared cell");
        rd(3, 8'h00, "R1 cleared cell");
        close_it();

        // R2 R5 R6: fill every cell, rows closed between
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) wr(r, c, pat(r, c));
            check(rd_oe == 1'b0, "R5 no drive on write", int'(rd_oe), 0);
            close_it();
        end
        // R4: page-mode reads of whole rows
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = COLS - 1; c >= 0; c--) rd(c, model[r][c], "R4 page read");
            close_it();
        end

        // R5 read after write in same open row
        open_row(0);
        wr(0, 3, 8'h77);
        rd(3, 8'h77, "R5 read after write");
        close_it();

        // R7 write-back on row switch
        open_row(1);
        wr(1, 2, 8'hA5);
        switch_row(3);
        rd(0, model[3][0], "R7 new row after switch");
        switch_row(1);
        rd(2, 8'hA5, "R7 old row written back");
        close_it();

        // R8 column strobes while closed
        col_stb = 1; col_wr = 1; addr = 2'd1; wr_data = 8'hFF;
        @(negedge clk); clr();
        check(rd_oe == 1'b0, "R8 closed write no drive", int'(rd_oe), 0);
        col_stb = 1; addr = 2'd1;
        @(negedge clk); clr();
        check(rd_oe == 1'b0, "R8 closed read no drive", int'(rd_oe), 0);
        open_row(0);
        rd(1, model[0][1], "R8 closed write had no effect");
        close_it();

        // R9 refresh preserves contents and stays quiet
        refresh_req = 1; addr = 2'd2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); clr();
            check(rd_oe == 1'b0, "R9 quiet during refresh", int'(rd_oe), 0);
        end
        open_row(2);
        for (int c = 0; c < COLS; c++) rd(c, model[2][c], "R9 row intact after refresh");
        close_it();
        // R9 row strobe wins over refresh
        row_stb = 1; refresh_req = 1; addr = 2'd3;
        @(negedge clk); clr(); @(negedge clk);
        rd(1, model[3][1], "R9 row strobe beats refresh");
        close_it();

        // R10 commands during sensing ignored
        row_stb = 1; addr = 2'd1;
        @(negedge clk); clr();
        col_stb = 1; col_wr = 1; addr = 2'd0; wr_data = 8'hEE; close_row = 1;
        @(negedge clk); clr();
        rd(0, model[1][0], "R10 write during sense ignored");
        close_it();

        // R11 refresh ignored while open
        open_row(0);
        refresh_req = 1; addr = 2'd3;
        @(negedge clk); clr();
        rd(2, model[0][2], "R11 refresh ignored when open");
        // R11 close cancels same-cycle column write
        close_row = 1; col_stb = 1; col_wr = 1; addr = 2'd0; wr_data = 8'h33;
        @(negedge clk); clr(); @(negedge clk);
        open_row(0);
        rd(0, model[0][0], "R11 close beats column write");
        // R11 row strobe beats close and column read
        row_stb = 1; close_row = 1; col_stb = 1; addr = 2'd2;
        @(negedge clk); clr();
        check(rd_oe == 1'b0, "R11 column read cancelled", int'(rd_oe), 0);
        repeat (2) @(negedge clk);
        rd(3, model[2][3], "R11 row strobe won");
        close_it();

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
        finish_run();
    end

endmodule